// File: doc/BRIEF.md
# Vector Strided and Indexed Address Sequencer

This block generates the element addresses for a vector memory instruction. A command carries a base address, an addressing mode, a signed stride, an element size and a total element count. The block then emits one byte address per accepted output beat. Addresses can be contiguous, a fixed signed distance apart, or the base plus a scaled entry taken from an index stream. The same addresses serve loads that gather and stores that scatter. A long operation is strip-mined into chunks of at most `MAX_VL` elements. Every beat carries the length of its chunk, a flag on the final element of each chunk, and a flag on the final element of the whole operation.

Commands, indices and addresses each move over valid/ready handshakes. A transfer takes place on a rising edge where valid and ready are both high. The output is registered. While `out_valid` is high and `out_ready` is low, every output field is held unchanged. The index stream is consumed only in the cycle its element is loaded into the output register, so back-pressure on the output stalls index consumption too. A command is accepted only when no element is pending or waiting at the output. A plain `done` pulse reports completion.

Top module: `vec_addr_gen`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `done` are 0 and `cmd_ready` is 1.
- R2: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` 1, and `out_addr`, `out_vl`, `out_last` and `out_done` keep their values.
- R3: Mode code 0 (unit stride) gives element i the address base + i*size, and the stride input is ignored. Size code 0, 1, 2 and 3 means 1, 2, 4 and 8 bytes. Mode code 3 behaves as code 0.
- R4: Mode code 1 (strided) gives element i the address base + i*stride*size, modulo 2^ADDR_W, with the stride taken as signed 32-bit. A negative stride walks downward, and a zero stride repeats the base.
- R5: Mode code 2 (indexed) gives element i the address base + index_i*size, with each index taken as signed 32-bit. Exactly one index is taken per element. `idx_ready` is never high outside mode 2.
- R6: Elements are grouped in order into chunks of min(remaining, MAX_VL). Each beat reports its chunk's length on `out_vl` and raises `out_last` on the final element of its chunk.
- R7: Exactly `cmd_total` elements are emitted, in order, and strided addressing continues across chunk boundaries.
- R8: `out_done` is 1 only on the final element of the operation. `done` pulses for one cycle in the cycle after that element's handshake.
- R9: A command with `cmd_total` of 0 produces no output beat. `done` pulses in the cycle after the command is accepted.
- R10: `cmd_ready` is 0 from the cycle after a non-empty command is accepted until the final element has been handed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_base | input | ADDR_W | Base byte address |
| cmd_mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 unit |
| cmd_stride | input | 32 | Signed stride in elements |
| cmd_esize | input | 2 | log2 of the element size in bytes |
| cmd_total | input | CNT_W | Total element count |
| idx_valid | input | 1 | Index offered |
| idx_ready | output | 1 | Index taken on this edge if valid |
| idx_data | input | 32 | Signed index in elements |
| out_valid | output | 1 | Address beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_addr | output | ADDR_W | Element byte address |
| out_vl | output | VL_W | Length of the current chunk |
| out_last | output | 1 | Final element of the chunk |
| out_done | output | 1 | Final element of the operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume reset is applied before the first command, and that a command's fields matter only on its accepting edge. They place no limit on when `out_ready` or `idx_valid` may change. The stimulus therefore toggles both at random during the long strided and indexed runs. It drives every command field only together with `cmd_valid`, from the falling edge, and holds it until the handshake.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_RSVD   = 2'd3
  } vag_mode_e;
endpackage

// File: rtl/vag_scale.sv
// Sign-extends a 32-bit element count and scales it to bytes.
module vag_scale #(
  parameter int ADDR_W = 32
) (
  input  logic [31:0]       val,
  input  logic [1:0]        esize,
  output logic [ADDR_W-1:0] scaled
);
  logic [ADDR_W-1:0] wide;

  generate
    if (ADDR_W > 32) begin : g_ext
      assign wide = {{(ADDR_W-32){val[31]}}, val};
    end else begin : g_trunc
      assign wide = val[ADDR_W-1:0];
    end
  endgenerate

  assign scaled = wide << esize;
endmodule

// File: rtl/vag_chunk.sv
// Length of the next strip: the remaining count clipped to the hardware maximum.
module vag_chunk #(
  parameter int MAX_VL = 64,
  parameter int CNT_W  = 16,
  parameter int VL_W   = 7
) (
  input  logic [CNT_W-1:0] count,
  output logic [VL_W-1:0]  len
);
  always_comb begin
    if (count > CNT_W'(MAX_VL)) len = VL_W'(MAX_VL);
    else                        len = count[VL_W-1:0];
  end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [1:0]        cmd_mode,
  input  logic [31:0]       cmd_stride,
  input  logic [1:0]        cmd_esize,
  input  logic [CNT_W-1:0]  cmd_total,
  input  logic              idx_valid,
  output logic              idx_ready,
  input  logic [31:0]       idx_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [VL_W-1:0]   out_vl,
  output logic              out_last,
  output logic              out_done,
  output logic              done
);
  vag_mode_e         mode_q;
  logic [1:0]        esize_q;
  logic              pend_q;
  logic [CNT_W-1:0]  rem_q;
  logic [VL_W-1:0]   left_q, cur_len_q;
  logic [ADDR_W-1:0] base_q, run_q, step_q;
  logic              out_valid_q, out_last_q, out_done_q, done_q;
  logic [ADDR_W-1:0] out_addr_q;
  logic [VL_W-1:0]   out_vl_q;

  logic              cmd_fire, slot_free, is_idx, issue;
  logic [31:0]       step_src;
  logic [ADDR_W-1:0] step_new, idx_off;
  logic [CNT_W-1:0]  rem_dec;
  logic [VL_W-1:0]   first_len, next_len;

  assign cmd_ready = !pend_q && !out_valid_q;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign slot_free = !out_valid_q || out_ready;
  assign is_idx    = (mode_q == MODE_INDEX);
  assign idx_ready = pend_q && is_idx && slot_free;
  assign issue     = pend_q && slot_free && (!is_idx || idx_valid);
  assign rem_dec   = rem_q - CNT_W'(1);
  assign step_src  = (vag_mode_e'(cmd_mode) == MODE_STRIDE) ? cmd_stride : 32'd1;

  vag_scale #(.ADDR_W(ADDR_W)) u_step_scale (
    .val(step_src), .esize(cmd_esize), .scaled(step_new)
  );
  vag_scale #(.ADDR_W(ADDR_W)) u_idx_scale (
    .val(idx_data), .esize(esize_q), .scaled(idx_off)
  );
  vag_chunk #(.MAX_VL(MAX_VL), .CNT_W(CNT_W), .VL_W(VL_W)) u_first_chunk (
    .count(cmd_total), .len(first_len)
  );
  vag_chunk #(.MAX_VL(MAX_VL), .CNT_W(CNT_W), .VL_W(VL_W)) u_next_chunk (
    .count(rem_dec), .len(next_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_UNIT;
      esize_q     <= '0;
      pend_q      <= 1'b0;
      rem_q       <= '0;
      left_q      <= '0;
      cur_len_q   <= '0;
      base_q      <= '0;
      run_q       <= '0;
      step_q      <= '0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_done_q  <= 1'b0;
      out_addr_q  <= '0;
      out_vl_q    <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= (cmd_fire && (cmd_total == '0)) ||
                (out_valid_q && out_ready && out_done_q);
      if (cmd_fire) begin
        mode_q    <= vag_mode_e'(cmd_mode);
        esize_q   <= cmd_esize;
        base_q    <= cmd_base;
        run_q     <= cmd_base;
        step_q    <= step_new;
        rem_q     <= cmd_total;
        left_q    <= first_len;
        cur_len_q <= first_len;
        pend_q    <= (cmd_total != '0);
      end
      if (issue) begin
        out_valid_q <= 1'b1;
        out_addr_q  <= is_idx ? (base_q + idx_off) : run_q;
        out_vl_q    <= cur_len_q;
        out_last_q  <= (left_q == VL_W'(1));
        out_done_q  <= (rem_q == CNT_W'(1));
        run_q       <= run_q + step_q;
        rem_q       <= rem_dec;
        pend_q      <= (rem_q != CNT_W'(1));
        if (left_q == VL_W'(1)) begin
          left_q    <= next_len;
          cur_len_q <= next_len;
        end else begin
          left_q    <= left_q - VL_W'(1);
        end
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_addr  = out_addr_q;
  assign out_vl    = out_vl_q;
  assign out_last  = out_last_q;
  assign out_done  = out_done_q;
  assign done      = done_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_vl)
      && $stable(out_last) && $stable(out_done));

  p_idx_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> (mode_q == MODE_INDEX) && pend_q);

  p_vl_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vl != '0) && (out_vl <= VL_W'(MAX_VL)));

  p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_done |-> out_last);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_done |=> done && !out_valid);

  p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_total == '0) |=> done && !out_valid);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_total != '0) |=> !cmd_ready);
endmodule

// File: tb/vec_addr_gen_tb_top.sv
module vec_addr_gen_tb_top;
  localparam int MAXV = 64;

  typedef struct packed {
    logic [31:0] a;
    logic        l;
    logic        d;
    logic [6:0]  vl;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_base = '0, cmd_stride = '0;
  logic [1:0]  cmd_mode = '0, cmd_esize = '0;
  logic [15:0] cmd_total = '0;
  logic        idx_valid = 1'b0, idx_ready;
  logic [31:0] idx_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [6:0]  out_vl;
  logic        out_last, out_done, done;

  always #2 clk = ~clk;

  vec_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
    .cmd_mode(cmd_mode), .cmd_stride(cmd_stride), .cmd_esize(cmd_esize),
    .cmd_total(cmd_total),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_vl(out_vl), .out_last(out_last), .out_done(out_done), .done(done)
  );

  exp_t        expq[$];
  logic [31:0] idxq[$];
  exp_t        e;
  int          n_chk = 0, n_bad = 0, done_cnt = 0;
  bit          bp_en = 0, gap_en = 0, idx_take = 0, hold_pend = 0;
  logic [31:0] hold_addr;
  string       cur_req = "R3";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // Monitor and stream drivers: drive at the falling edge, sample 1 ns later.
  always begin
    @(negedge clk);
    if (idx_take) begin
      void'(idxq.pop_front());
      idx_take = 0;
    end
    idx_valid = (idxq.size() > 0) && (!gap_en || ($urandom % 3 != 0));
    idx_data  = (idxq.size() > 0) ? idxq[0] : 32'd0;
    out_ready = !bp_en || ($urandom % 2 == 0);
    #1;
    if (rst_n) begin
      idx_take = idx_valid && idx_ready;
      if (hold_pend) begin
        chk(out_valid && out_addr == hold_addr, "R2", "held address", out_addr, hold_addr);
        hold_pend = 0;
      end
      if (out_valid && !out_ready) begin
        hold_pend = 1;
        hold_addr = out_addr;
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R7", "unexpected element", out_addr, 0);
        end else begin
          e = expq.pop_front();
          chk(out_addr == e.a, cur_req, "address", out_addr, e.a);
          chk(out_vl == e.vl, "R6", "chunk length", out_vl, e.vl);
          chk(out_last == e.l, "R6", "chunk last", out_last, e.l);
          chk(out_done == e.d, "R8", "final flag", out_done, e.d);
        end
      end
      if (done) done_cnt++;
    end
  end

  task automatic run(input logic [31:0] base, input logic [1:0] mode,
                     input logic [31:0] stride, input logic [1:0] es,
                     input int total, input string req);
    logic [31:0] step = ((mode == 2'd1) ? stride : 32'd1) << es;
    int d0;
    for (int i = 0; i < total; i++) begin
      int c = i / MAXV;
      int vl = ((total - c * MAXV) > MAXV) ? MAXV : (total - c * MAXV);
      logic [31:0] a;
      logic [31:0] ix;
      if (mode == 2'd2) begin
        ix = ($urandom % 512) - 32'd256;
        idxq.push_back(ix);
        a = base + (ix << es);
      end else begin
        a = base + step * 32'(i);
      end
      expq.push_back('{a, (i % MAXV == MAXV - 1) || (i == total - 1),
                       i == total - 1, 7'(vl)});
    end
    cur_req = req;
    d0 = done_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_base = base; cmd_mode = mode;
    cmd_stride = stride; cmd_esize = es; cmd_total = 16'(total);
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    if (total == 0) begin
      chk(done && !out_valid, "R9", "done after empty command", {out_valid, done}, 2'b01);
      chk(cmd_ready, "R9", "ready after empty command", cmd_ready, 1);
    end else begin
      chk(!cmd_ready, "R10", "busy blocks commands", cmd_ready, 0);
      while (done_cnt == d0) begin
        @(negedge clk);
        #2;
      end
      chk(expq.size() == 0, "R7", "elements left unseen", expq.size(), 0);
      chk(!out_valid && cmd_ready, "R8", "idle after done", {out_valid, cmd_ready}, 2'b01);
      if (mode == 2'd2)
        chk(idxq.size() == 0, "R5", "indices left", idxq.size(), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R1", "valid in reset", out_valid, 0);
    chk(cmd_ready, "R1", "ready in reset", cmd_ready, 1);
    chk(!done, "R1", "done in reset", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(32'h0000_1000, 2'd0, 32'd99, 2'd2, 5, "R3");
    run(32'h0000_0300, 2'd3, 32'd7, 2'd3, 3, "R3");
    run(32'h0000_8000, 2'd1, 32'hFFFF_FFFD, 2'd3, 10, "R4");
    run(32'h0000_4000, 2'd1, 32'd0, 2'd1, 4, "R4");
    bp_en = 1;
    run(32'h0001_0000, 2'd1, 32'd3, 2'd0, 150, "R4");
    gap_en = 1;
    run(32'h2000_0000, 2'd2, 32'd0, 2'd3, 70, "R5");
    run(32'h0000_0100, 2'd0, 32'd0, 2'd0, 64, "R6");
    run(32'h0000_0000, 2'd1, 32'd5, 2'd2, 0, "R9");
    run(32'h0000_0040, 2'd0, 32'd0, 2'd3, 1, "R8");
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule